// File: doc/BRIEF.md
# System Exception Control Register File

This block is the register file through which software controls the processor's system exceptions. There are eight of them: the non-maskable interrupt, the pendable service request, the tick timer, memory-manage, bus fault, usage fault, supervisor call and debug. For each exception the block holds a pending bit and an active bit. It also holds an enable bit for the three fault exceptions, twelve 8-bit handler priorities and the vector table base. It also takes keyed requests for a system reset.

Software reaches the block through a word-wide port with a 12-bit byte offset. Writes take effect at the clock edge. Read data is a combinational function of the offset. Other logic reads the per-exception pending, active and enable vectors, the priorities, the vector base and the reset request. The same logic drives set-pending, acknowledge and completion strobes into the block. Arbitration between exceptions and the vector fetch are done outside the block.

All per-exception vectors use one bit order:

| Bit | Exception |
|-----|-----------|
| 0 | NMI |
| 1 | memory-manage |
| 2 | bus fault |
| 3 | usage fault |
| 4 | supervisor call |
| 5 | debug |
| 6 | service request |
| 7 | tick timer |

Top module: `sexc_regfile`

## Requirements
- R1: After reset, every pending and active bit is 0, the three configurable enables are 0, all priorities are 0, the vector base is 0 and the reset request is low. `exc_enable_o` reads 8'hF1, because NMI, supervisor call, debug, service request and tick timer are always enabled.
- R2: A write to offset 0xD04 with bit 31 set makes NMI pending. A read of 0xD04 returns the following pending bits and zero elsewhere:
  - bit 31: NMI
  - bit 28: service request
  - bit 26: tick timer
- R3: In a write to 0xD04, bit 28 sets service-request pending and bit 27 clears it. When both bits are 1, the set wins.
- R4: In a write to 0xD04, bit 26 sets tick-timer pending and bit 25 clears it. When both bits are 1, the set wins.
- R5: Offset 0xD08 holds the vector table base. Bits 6:0 of the written value are discarded and read back as zero, on the port and on `vtor_o`.
- R6: A write to 0xD0C acts only when bits 31:16 equal 16'h05FA. Such a write with bit 2 set raises `sys_reset_req_o`, which stays high until reset. A write with any other key has no effect.
- R7: Offsets 0xD18, 0xD1C and 0xD20 each hold four 8-bit priorities, for handlers 4-7, 8-11 and 12-15 respectively. The lowest-numbered handler of each word is in bits 7:0. The word is readable, and handler h appears at `prio_o[8*(h-4)+:8]`.
- R8: A read of 0xD24 reports status at these bit positions:
  - Active bits:
    - bit 0: memory-manage
    - bit 1: bus fault
    - bit 3: usage fault
    - bit 7: supervisor call
    - bit 8: debug
    - bit 10: service request
    - bit 11: tick timer
  - Pending bits:
    - bit 12: usage fault
    - bit 13: memory-manage
    - bit 14: bus fault
    - bit 15: supervisor call
- R9: In 0xD24, only bits 16 (memory-manage enable), 17 (bus fault enable) and 18 (usage fault enable) are writable. These bits read back and drive `exc_enable_o[1]`, `[2]` and `[3]`. All other written bits are ignored.
- R10: A read of offset 0x004 returns NUM_IRQ/32 - 1, which is 1 with the defaults.
- R11: A pulse on `exc_ack_i[k]` clears pending bit k and sets active bit k at the same edge. A pulse on `exc_done_i[k]` clears active bit k. When ack and done coincide, active stays set. When a set-pending strobe coincides with an ack, pending stays set.
- R12: A pulse on `exc_set_pend_i[k]` sets pending bit k at the next edge.
- R13: Reads of any offset not listed above return zero. Writes to such offsets change no state and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte offset of the access; bits 1:0 are ignored |
| reg_we | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| exc_set_pend_i | input | 8 | Per-exception set-pending strobes |
| exc_ack_i | input | 8 | Per-exception acknowledge strobes |
| exc_done_i | input | 8 | Per-exception completion strobes |
| exc_pending_o | output | 8 | Pending bits |
| exc_active_o | output | 8 | Active bits |
| exc_enable_o | output | 8 | Enable bits |
| prio_o | output | 96 | Handler priorities 4..15, 8 bits each |
| vtor_o | output | 32 | Vector table base |
| sys_reset_req_o | output | 1 | Sticky system reset request |

## Verification
The hardest status word to reach from the ports is the one read at 0xD24 while pending and active bits are mixed across exceptions. That read is the only place where the scattered bit positions can be told apart. To reach it, the stimulus first sets pending on the four fault and call exceptions with one strobe. It then acknowledges a single exception and reads the word. Next it acknowledges the remaining exceptions and reads the word again. Each read has a distinct expected pattern. Coincident strobes (set with ack, ack with done) are driven in the same cycle to check which event wins.

// File: rtl/sexc_pkg.sv
package sexc_pkg;

    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int NUM_EXC = 8;

    // Bit order of every per-exception vector
    localparam int EXC_NMI    = 0;
    localparam int EXC_MEM    = 1;
    localparam int EXC_BUS    = 2;
    localparam int EXC_USAGE  = 3;
    localparam int EXC_SVC    = 4;
    localparam int EXC_DEBUG  = 5;
    localparam int EXC_PENDSV = 6;
    localparam int EXC_TICK   = 7;

    // Exceptions whose enable cannot be turned off
    localparam logic [NUM_EXC-1:0] FIXED_EN = 8'hF1;

    // Byte offsets of the implemented words
    localparam logic [ADDR_W-1:0] REG_CTRLTYPE  = 12'h004;
    localparam logic [ADDR_W-1:0] REG_INTSTATE  = 12'hD04;
    localparam logic [ADDR_W-1:0] REG_VECBASE   = 12'hD08;
    localparam logic [ADDR_W-1:0] REG_RSTCTRL   = 12'hD0C;
    localparam logic [ADDR_W-1:0] REG_PRIO_BASE = 12'hD18;
    localparam logic [ADDR_W-1:0] REG_HSTAT     = 12'hD24;

    // Interrupt state write bits
    localparam int IS_NMI_SET  = 31;
    localparam int IS_SRV_SET  = 28;
    localparam int IS_SRV_CLR  = 27;
    localparam int IS_TICK_SET = 26;
    localparam int IS_TICK_CLR = 25;

    // Reset control
    localparam logic [15:0] RST_KEY     = 16'h05FA;
    localparam int          RST_REQ_BIT = 2;

    // Vector base alignment
    localparam int VB_ZERO_BITS = 7;
    localparam int VB_W         = DATA_W - VB_ZERO_BITS;

    // Handler status enable bits
    localparam int HS_EN_LSB = 16;
    localparam int CFG_EN_W  = 3;

    typedef struct packed {
        logic ctrltype;
        logic intstate;
        logic vecbase;
        logic rstctrl;
        logic hstat;
    } sexc_sel_t;

    typedef struct packed {
        logic [NUM_EXC-1:0]  pend;
        logic [NUM_EXC-1:0]  act;
        logic [CFG_EN_W-1:0] cfg_en;   // 0 mem, 1 bus, 2 usage
        logic [VB_W-1:0]     vbase;
        logic                rst_req;
    } sexc_state_t;

endpackage

// File: rtl/sexc_decode.sv
module sexc_decode
    import sexc_pkg::*;
#(
    parameter int PRIO_WORDS = 3
) (
    input  logic [ADDR_W-1:0]     addr,
    output sexc_sel_t             sel,
    output logic [PRIO_WORDS-1:0] prio_sel
);

    localparam int WA_W = ADDR_W - 2;

    logic [WA_W-1:0] word_addr;

    assign word_addr = addr[ADDR_W-1:2];

    always_comb begin
        sel          = '0;
        sel.ctrltype = (word_addr == REG_CTRLTYPE[ADDR_W-1:2]);
        sel.intstate = (word_addr == REG_INTSTATE[ADDR_W-1:2]);
        sel.vecbase  = (word_addr == REG_VECBASE[ADDR_W-1:2]);
        sel.rstctrl  = (word_addr == REG_RSTCTRL[ADDR_W-1:2]);
        sel.hstat    = (word_addr == REG_HSTAT[ADDR_W-1:2]);
    end

    for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_prio_dec
        assign prio_sel[w] = (word_addr == (REG_PRIO_BASE[ADDR_W-1:2] + WA_W'(w)));
    end

endmodule

// File: rtl/sexc_prio_bank.sv
module sexc_prio_bank
    import sexc_pkg::*;
#(
    parameter int PRIO_WORDS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [PRIO_WORDS-1:0]        sel,
    input  logic [DATA_W-1:0]            wdata,
    output logic [PRIO_WORDS*DATA_W-1:0] words_o
);

    for (genvar w = 0; w < PRIO_WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_d;
        logic [DATA_W-1:0] word_q;

        always_comb begin
            word_d = word_q;
            if (we && sel[w]) begin
                word_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end

        assign words_o[w*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/sexc_readmux.sv
module sexc_readmux
    import sexc_pkg::*;
#(
    parameter int PRIO_WORDS = 3
) (
    input  sexc_sel_t                    sel,
    input  logic [PRIO_WORDS-1:0]        prio_sel,
    input  logic [PRIO_WORDS*DATA_W-1:0] prio_words,
    input  sexc_state_t                  st,
    input  logic [DATA_W-1:0]            ctrltype_val,
    output logic [DATA_W-1:0]            rdata
);

    logic [DATA_W-1:0] intstate_rd;
    logic [DATA_W-1:0] hstat_rd;

    always_comb begin
        intstate_rd              = '0;
        intstate_rd[IS_NMI_SET]  = st.pend[EXC_NMI];
        intstate_rd[IS_SRV_SET]  = st.pend[EXC_PENDSV];
        intstate_rd[IS_TICK_SET] = st.pend[EXC_TICK];
    end

    always_comb begin
        hstat_rd     = '0;
        hstat_rd[0]  = st.act[EXC_MEM];
        hstat_rd[1]  = st.act[EXC_BUS];
        hstat_rd[3]  = st.act[EXC_USAGE];
        hstat_rd[7]  = st.act[EXC_SVC];
        hstat_rd[8]  = st.act[EXC_DEBUG];
        hstat_rd[10] = st.act[EXC_PENDSV];
        hstat_rd[11] = st.act[EXC_TICK];
        hstat_rd[12] = st.pend[EXC_USAGE];
        hstat_rd[13] = st.pend[EXC_MEM];
        hstat_rd[14] = st.pend[EXC_BUS];
        hstat_rd[15] = st.pend[EXC_SVC];
        hstat_rd[HS_EN_LSB +: CFG_EN_W] = st.cfg_en;
    end

    always_comb begin
        rdata = '0;
        if (sel.ctrltype) begin
            rdata = ctrltype_val;
        end
        if (sel.intstate) begin
            rdata = intstate_rd;
        end
        if (sel.vecbase) begin
            rdata = {st.vbase, {VB_ZERO_BITS{1'b0}}};
        end
        if (sel.hstat) begin
            rdata = hstat_rd;
        end
        for (int w = 0; w < PRIO_WORDS; w++) begin
            if (prio_sel[w]) begin
                rdata = prio_words[w*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/sexc_regfile.sv
module sexc_regfile
    import sexc_pkg::*;
#(
    parameter int NUM_IRQ    = 64,
    parameter int PRIO_WORDS = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic                         reg_we,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [DATA_W-1:0]            reg_rdata,
    input  logic [NUM_EXC-1:0]           exc_set_pend_i,
    input  logic [NUM_EXC-1:0]           exc_ack_i,
    input  logic [NUM_EXC-1:0]           exc_done_i,
    output logic [NUM_EXC-1:0]           exc_pending_o,
    output logic [NUM_EXC-1:0]           exc_active_o,
    output logic [NUM_EXC-1:0]           exc_enable_o,
    output logic [PRIO_WORDS*DATA_W-1:0] prio_o,
    output logic [DATA_W-1:0]            vtor_o,
    output logic                         sys_reset_req_o
);

    localparam logic [DATA_W-1:0] CTRLTYPE_VAL = DATA_W'(NUM_IRQ / 32 - 1);

    sexc_sel_t             sel;
    logic [PRIO_WORDS-1:0] prio_sel;
    sexc_state_t           st_d;
    sexc_state_t           st_q;
    logic [NUM_EXC-1:0]    sw_set;
    logic [NUM_EXC-1:0]    sw_clr;

    sexc_decode #(.PRIO_WORDS(PRIO_WORDS)) u_decode (
        .addr     (reg_addr),
        .sel      (sel),
        .prio_sel (prio_sel)
    );

    sexc_prio_bank #(.PRIO_WORDS(PRIO_WORDS)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .sel     (prio_sel),
        .wdata   (reg_wdata),
        .words_o (prio_o)
    );

    // Software set/clear of pending bits from the interrupt state word
    always_comb begin
        sw_set = '0;
        sw_clr = '0;
        if (reg_we && sel.intstate) begin
            sw_set[EXC_NMI]    = reg_wdata[IS_NMI_SET];
            sw_set[EXC_PENDSV] = reg_wdata[IS_SRV_SET];
            sw_clr[EXC_PENDSV] = reg_wdata[IS_SRV_CLR];
            sw_set[EXC_TICK]   = reg_wdata[IS_TICK_SET];
            sw_clr[EXC_TICK]   = reg_wdata[IS_TICK_CLR];
        end
    end

    always_comb begin
        st_d = st_q;
        // set beats clear and acknowledge
        st_d.pend = (st_q.pend & ~sw_clr & ~exc_ack_i) | sw_set | exc_set_pend_i;
        // acknowledge beats completion
        st_d.act  = (st_q.act & ~exc_done_i) | exc_ack_i;
        if (reg_we && sel.hstat) begin
            st_d.cfg_en = reg_wdata[HS_EN_LSB +: CFG_EN_W];
        end
        if (reg_we && sel.vecbase) begin
            st_d.vbase = reg_wdata[DATA_W-1:VB_ZERO_BITS];
        end
        if (reg_we && sel.rstctrl && (reg_wdata[DATA_W-1:16] == RST_KEY)
            && reg_wdata[RST_REQ_BIT]) begin
            st_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sexc_readmux #(.PRIO_WORDS(PRIO_WORDS)) u_rmux (
        .sel          (sel),
        .prio_sel     (prio_sel),
        .prio_words   (prio_o),
        .st           (st_q),
        .ctrltype_val (CTRLTYPE_VAL),
        .rdata        (reg_rdata)
    );

    always_comb begin
        exc_enable_o            = FIXED_EN;
        exc_enable_o[EXC_MEM]   = st_q.cfg_en[0];
        exc_enable_o[EXC_BUS]   = st_q.cfg_en[1];
        exc_enable_o[EXC_USAGE] = st_q.cfg_en[2];
    end

    assign exc_pending_o   = st_q.pend;
    assign exc_active_o    = st_q.act;
    assign vtor_o          = {st_q.vbase, {VB_ZERO_BITS{1'b0}}};
    assign sys_reset_req_o = st_q.rst_req;

endmodule

module sexc_regfile_chk
    import sexc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_we,
    input logic [DATA_W-1:0]  reg_wdata,
    input logic [NUM_EXC-1:0] exc_set_pend_i,
    input logic [NUM_EXC-1:0] exc_ack_i,
    input logic [NUM_EXC-1:0] exc_done_i,
    input logic [NUM_EXC-1:0] exc_pending_o,
    input logic [NUM_EXC-1:0] exc_active_o,
    input logic               sys_reset_req_o
);

    logic is_wr;
    logic rst_wr;

    assign is_wr  = reg_we && (reg_addr[ADDR_W-1:2] == REG_INTSTATE[ADDR_W-1:2]);
    assign rst_wr = reg_we && (reg_addr[ADDR_W-1:2] == REG_RSTCTRL[ADDR_W-1:2])
                    && (reg_wdata[31:16] == RST_KEY) && reg_wdata[RST_REQ_BIT];

    assert_srv_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && reg_wdata[IS_SRV_SET]) |=> exc_pending_o[EXC_PENDSV]);

    assert_tick_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && reg_wdata[IS_TICK_CLR] && !reg_wdata[IS_TICK_SET] && !exc_set_pend_i[EXC_TICK])
        |=> !exc_pending_o[EXC_TICK]);

    assert_keyed_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset_req_o) |-> $past(rst_wr));

    assert_ack_sets_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ack_i != '0) |=> ((exc_active_o & $past(exc_ack_i)) == $past(exc_ack_i)));

    assert_done_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((exc_done_i & ~exc_ack_i) != '0) |=> ((exc_active_o & $past(exc_done_i & ~exc_ack_i)) == '0));

    assert_set_pend_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_set_pend_i != '0) |=> ((exc_pending_o & $past(exc_set_pend_i)) == $past(exc_set_pend_i)));

endmodule

bind sexc_regfile sexc_regfile_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_addr        (reg_addr),
    .reg_we          (reg_we),
    .reg_wdata       (reg_wdata),
    .exc_set_pend_i  (exc_set_pend_i),
    .exc_ack_i       (exc_ack_i),
    .exc_done_i      (exc_done_i),
    .exc_pending_o   (exc_pending_o),
    .exc_active_o    (exc_active_o),
    .sys_reset_req_o (sys_reset_req_o)
);

// File: tb/sexc_regfile_bench.sv
module sexc_regfile_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  set_pend = '0;
    logic [7:0]  ack = '0;
    logic [7:0]  done = '0;
    logic [7:0]  pend_o;
    logic [7:0]  act_o;
    logic [7:0]  en_o;
    logic [95:0] prio_o;
    logic [31:0] vtor_o;
    logic        rreq_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sexc_regfile u_sexc_regfile (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_addr        (reg_addr),
        .reg_we          (reg_we),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .exc_set_pend_i  (set_pend),
        .exc_ack_i       (ack),
        .exc_done_i      (done),
        .exc_pending_o   (pend_o),
        .exc_active_o    (act_o),
        .exc_enable_o    (en_o),
        .prio_o          (prio_o),
        .vtor_o          (vtor_o),
        .sys_reset_req_o (rreq_o)
    );

    task automatic check(string req, logic [95:0] act, logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic strobe(logic [7:0] s, logic [7:0] k, logic [7:0] c);
        @(negedge clk);
        set_pend = s; ack = k; done = c;
        @(negedge clk);
        set_pend = '0; ack = '0; done = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pending", pend_o, 0);
        check("R1 active", act_o, 0);
        check("R1 enable", en_o, 8'hF1);
        check("R1 prio", prio_o, 0);
        check("R1 vtor", vtor_o, 0);
        check("R1 rreq", rreq_o, 0);
        rd(12'hD24, d);
        check("R1 hstat", d, 0);
    endtask

    task automatic t_intstate();
        logic [31:0] d;
        wr(12'hD04, 32'h8000_0000);
        check("R2 nmi pend", pend_o, 8'h01);
        wr(12'hD04, 32'h1800_0000);
        check("R3 set wins", pend_o, 8'h41);
        wr(12'hD04, 32'h0800_0000);
        check("R3 clear", pend_o, 8'h01);
        wr(12'hD04, 32'h0600_0000);
        check("R4 set wins", pend_o, 8'h81);
        wr(12'hD04, 32'h1000_0000);
        rd(12'hD04, d);
        check("R2 readback", d, 32'h9400_0000);
        wr(12'hD04, 32'h0A00_0000);
        check("R4 clear", pend_o, 8'h01);
    endtask

    task automatic t_vecbase();
        logic [31:0] d;
        wr(12'hD08, 32'h2000_01FF);
        rd(12'hD08, d);
        check("R5 read", d, 32'h2000_0180);
        check("R5 vtor_o", vtor_o, 32'h2000_0180);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(12'hD18, 32'h4433_2211);
        wr(12'hD20, 32'hDDCC_BBAA);
        check("R7 handler4", prio_o[7:0], 8'h11);
        check("R7 handler7", prio_o[31:24], 8'h44);
        check("R7 handler15", prio_o[95:88], 8'hDD);
        check("R7 handler8 untouched", prio_o[63:32], 0);
        rd(12'hD20, d);
        check("R7 read", d, 32'hDDCC_BBAA);
    endtask

    task automatic t_enables();
        logic [31:0] d;
        wr(12'hD24, 32'hFFFF_FFFF);
        check("R9 enable_o", en_o, 8'hFF);
        rd(12'hD24, d);
        check("R9 read", d, 32'h0007_0000);
        check("R9 no active", act_o, 0);
        wr(12'hD24, 32'h0002_0000);
        check("R9 bus only", en_o, 8'hF5);
        wr(12'hD24, 32'h0);
        check("R9 cleared", en_o, 8'hF1);
    endtask

    task automatic t_status();
        logic [31:0] d;
        strobe(8'h1E, 8'h00, 8'h00);
        check("R12 set pend", pend_o, 8'h1F);
        rd(12'hD24, d);
        check("R8 pend bits", d, 32'h0000_F000);
        strobe(8'h00, 8'h02, 8'h00);
        check("R11 ack mem", {act_o, pend_o}, {8'h02, 8'h1D});
        rd(12'hD24, d);
        check("R8 mixed", d, 32'h0000_D001);
        strobe(8'h00, 8'hFC, 8'h00);
        rd(12'hD24, d);
        check("R8 all active", d, 32'h0000_0D8B);
        strobe(8'h00, 8'h00, 8'hFE);
        check("R11 done", act_o, 0);
        strobe(8'h04, 8'h04, 8'h00);
        check("R11 set beats ack", {act_o[2], pend_o[2]}, 2'b11);
        strobe(8'h00, 8'h04, 8'h04);
        check("R11 ack beats done", act_o[2], 1);
        strobe(8'h00, 8'h00, 8'h04);
        check("R11 done bus", act_o[2], 0);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        rd(12'h004, d);
        check("R10 type", d, 32'h1);
        wr(12'hD10, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        wr(12'hD28, 32'hFFFF_FFFF);
        rd(12'hD10, d);
        check("R13 read zero", d, 0);
        rd(12'hD28, d);
        check("R13 read zero 2", d, 0);
        rd(12'h004, d);
        check("R13 type kept", d, 32'h1);
        check("R13 state kept", {en_o, act_o, vtor_o}, {8'hF1, 8'h00, 32'h2000_0180});
    endtask

    task automatic t_rstreq();
        wr(12'hD0C, 32'h1234_0004);
        check("R6 bad key", rreq_o, 0);
        wr(12'hD0C, 32'h05FA_0000);
        check("R6 no bit", rreq_o, 0);
        wr(12'hD0C, 32'h05FA_0004);
        check("R6 request", rreq_o, 1);
        wr(12'hD0C, 32'h05FA_0000);
        check("R6 sticky", rreq_o, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_intstate();
        t_vecbase();
        t_prio();
        t_enables();
        t_status();
        t_misc();
        t_rstreq();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule